// File: doc/BRIEF.md
# Eight-Pin Bidirectional GPIO Port with Register Access

This block is an eight-pin general-purpose I/O port that is controlled through three byte-wide registers on a simple synchronous bus. Each pin has a direction bit in a configuration register and a level bit in a data register. Together, the two bits put the pin into one of four modes: a floating input, an input with a weak pull-up, a driven low output, or a driven high output. The block drives per-pin output-enable, output-value and pull-up-enable signals to a pad model. It also samples the pad levels back through a synchronizer.

A third register is read-only. It always reports the synchronized pad levels, whatever mode each pin is in. Software can therefore read the level of a pin that it is driving, as well as the level of one that it only observes. Bus writes land on the clock edge on which they are presented. Reads are combinational from the addressed register.

Two pins, 0 and 5, can leave reset in a mode other than floating input. That mode comes from a four-bit boot-mode input that is sampled while reset is held. All other pins always reset to floating input.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the configuration and data registers load 0x00, except the bits of pins 0 and 5, which load from `boot_mode`. With `boot_mode` = 0, every pin leaves reset as a floating input: `pad_oe`, `pad_out` and `pad_pu` are all 0x00.
- R2: `boot_mode[1:0]` is the reset {config, data} pair of pin 0, and `boot_mode[3:2]` is the reset {config, data} pair of pin 5.
- R3: A write with `bus_wr` high at address 0xB2 loads the data register on that clock edge. A write at 0xB3 loads the configuration register on that clock edge. Reading either address returns the register contents combinationally.
- R4: The mode of pin i is {config[i], data[i]}, where 00 is a floating input, 01 is an input with pull-up, 10 drives low and 11 drives high. At the outputs this gives `pad_oe[i]` = config[i], `pad_out[i]` = data[i] and `pad_pu[i]` = data[i] AND NOT config[i]. Each pin is set independently of the others.
- R5: Reading address 0xB4 returns the `pad_in` levels sampled two clock edges earlier, for every pin and in every mode.
- R6: Writes to address 0xB4 have no effect.
- R7: Any address other than 0xB2, 0xB3 and 0xB4 reads as 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mode | input | 4 | Reset {config,data} pairs for pin 0 ([1:0]) and pin 5 ([3:2]) |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data from the addressed register |
| pad_in | input | 8 | Pad levels seen by the pins |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin weak pull-up enable |

## Verification
The bench puts every pin into each of the four modes together, then into one mixed byte in which neighbouring pins differ. This separates a swapped config/data pair, or a pin-index mix-up, from a correct decode. An external pattern on the floating pins, alternating with driven and pulled-up pins, shows whether the input register reports true pad levels rather than the data register. Reset runs with two non-zero boot codes and with zero, which exposes swapped boot-code fields and any leak into the other pins. Writes to the input register and to nearby unmapped addresses show that only exact address matches have an effect.

// File: rtl/gpio_port_pkg.sv
// Package gpio_port_pkg
// Shared mode encoding and pad-control type for the GPIO port.
// Assumes one configuration bit and one data bit per pin.
package gpio_port_pkg;

    typedef enum logic [1:0] {
        MODE_FLOAT  = 2'b00,
        MODE_PULLUP = 2'b01,
        MODE_DRIVE0 = 2'b10,
        MODE_DRIVE1 = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic oe;
        logic val;
        logic pu;
    } pad_ctrl_t;

    // Translate one pin mode into its pad controls
    function automatic pad_ctrl_t decode_mode(pin_mode_e mode);
        pad_ctrl_t c;
        c = '0;
        case (mode)
            MODE_FLOAT:  c = '{oe: 1'b0, val: 1'b0, pu: 1'b0};
            MODE_PULLUP: c = '{oe: 1'b0, val: 1'b1, pu: 1'b1};
            MODE_DRIVE0: c = '{oe: 1'b1, val: 1'b0, pu: 1'b0};
            MODE_DRIVE1: c = '{oe: 1'b1, val: 1'b1, pu: 1'b0};
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
// Module gpio_cfg_regs
// Holds the configuration and data registers of the port.
// Assumes: synchronous active-low reset; boot_mode is stable while reset
// is held; ALT_PIN_A and ALT_PIN_B are distinct pins below PINS.
module gpio_cfg_regs #(
    parameter int unsigned PINS      = 8,
    parameter int unsigned ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_DATA = 8'hB2,
    parameter logic [ADDR_W-1:0] ADDR_CFG  = 8'hB3,
    parameter int unsigned ALT_PIN_A = 0,
    parameter int unsigned ALT_PIN_B = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        boot_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   cfg_q,
    output logic [PINS-1:0]   data_q
);

    logic [PINS-1:0] cfg_rst;
    logic [PINS-1:0] data_rst;
    logic            cfg_we;
    logic            data_we;

    // Build the reset image from the boot-mode pairs
    always_comb begin
        cfg_rst             = '0;
        data_rst            = '0;
        cfg_rst[ALT_PIN_A]  = boot_mode[1];
        data_rst[ALT_PIN_A] = boot_mode[0];
        cfg_rst[ALT_PIN_B]  = boot_mode[3];
        data_rst[ALT_PIN_B] = boot_mode[2];
    end

    // Decode the write strobes for the two writable registers
    always_comb begin
        cfg_we  = bus_wr && (bus_addr == ADDR_CFG);
        data_we = bus_wr && (bus_addr == ADDR_DATA);
    end

    // Configuration register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= cfg_rst;
        end else if (cfg_we) begin
            cfg_q <= bus_wdata;
        end
    end

    // Data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= data_rst;
        end else if (data_we) begin
            data_q <= bus_wdata;
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module gpio_in_sync
// Multi-stage synchronizer for the pad levels. The input buffer is
// treated as an ideal hysteresis buffer, so only the flop chain is built.
// Assumes STAGES >= 1; all stages clear to 0 in reset.
module gpio_in_sync #(
    parameter int unsigned PINS   = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pins_sync
);

    logic [PINS-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage captures the raw pad levels
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= pad_in;
            end
        end else begin : g_next
            // Later stages shift the previous stage along
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign pins_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_drv.sv
// Module gpio_pad_drv
// Turns each pin's {config,data} pair into pad controls.
// Purely combinational; assumes no ordering between the pins.
module gpio_pad_drv
    import gpio_port_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input  logic [PINS-1:0] cfg_q,
    input  logic [PINS-1:0] data_q,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_pu
);

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pin_mode_e mode;
        pad_ctrl_t ctrl;
        // Decode this pin's mode into its pad controls
        always_comb begin
            mode = pin_mode_e'({cfg_q[i], data_q[i]});
            ctrl = decode_mode(mode);
        end
        assign pad_oe[i]  = ctrl.oe;
        assign pad_out[i] = ctrl.val;
        assign pad_pu[i]  = ctrl.pu;
    end

endmodule

// File: rtl/gpio_port.sv
// Module gpio_port
// Top of the GPIO port: register file, pad decoder, input synchronizer
// and the combinational read mux. Assumes a single-cycle bus without
// wait states; unmapped addresses read as zero.
module gpio_port #(
    parameter int unsigned PINS        = 8,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] ADDR_DATA = 8'hB2,
    parameter logic [ADDR_W-1:0] ADDR_CFG  = 8'hB3,
    parameter logic [ADDR_W-1:0] ADDR_PIN  = 8'hB4,
    parameter int unsigned ALT_PIN_A   = 0,
    parameter int unsigned ALT_PIN_B   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        boot_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_pu
);

    logic [PINS-1:0] cfg_q;
    logic [PINS-1:0] data_q;
    logic [PINS-1:0] pins_sync;

    gpio_cfg_regs #(
        .PINS      (PINS),
        .ADDR_W    (ADDR_W),
        .ADDR_DATA (ADDR_DATA),
        .ADDR_CFG  (ADDR_CFG),
        .ALT_PIN_A (ALT_PIN_A),
        .ALT_PIN_B (ALT_PIN_B)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_mode (boot_mode),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .cfg_q     (cfg_q),
        .data_q    (data_q)
    );

    gpio_pad_drv #(
        .PINS (PINS)
    ) i_drv (
        .cfg_q   (cfg_q),
        .data_q  (data_q),
        .pad_oe  (pad_oe),
        .pad_out (pad_out),
        .pad_pu  (pad_pu)
    );

    gpio_in_sync #(
        .PINS   (PINS),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_in    (pad_in),
        .pins_sync (pins_sync)
    );

    // Select the addressed register for the read port
    always_comb begin
        if (bus_addr == ADDR_DATA)      bus_rdata = data_q;
        else if (bus_addr == ADDR_CFG)  bus_rdata = cfg_q;
        else if (bus_addr == ADDR_PIN)  bus_rdata = pins_sync;
        else                            bus_rdata = '0;
    end

endmodule

// File: rtl/gpio_port_chk.sv
// Module gpio_port_chk
// Port-level assertions for gpio_port, attached with bind below.
// Assumes the default synchronizer depth of two stages.
module gpio_port_chk #(
    parameter int unsigned PINS   = 8,
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_DATA = 8'hB2,
    parameter logic [ADDR_W-1:0] ADDR_CFG  = 8'hB3,
    parameter logic [ADDR_W-1:0] ADDR_PIN  = 8'hB4,
    parameter int unsigned ALT_PIN_A = 0,
    parameter int unsigned ALT_PIN_B = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        boot_mode,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pad_in,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_pu
);

    localparam logic [PINS-1:0] ALT_MASK =
        (PINS'(1) << ALT_PIN_A) | (PINS'(1) << ALT_PIN_B);

    logic [1:0] since_rst;
    logic       mapped;

    // Count cycles since reset release, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // Flag addresses that decode to a register
    always_comb begin
        mapped = (bus_addr == ADDR_DATA) || (bus_addr == ADDR_CFG) ||
                 (bus_addr == ADDR_PIN);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (((pad_oe | pad_out | pad_pu) & ~ALT_MASK) == '0));

    // R2
    boot_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe[ALT_PIN_A] == $past(boot_mode[1]) &&
                          pad_out[ALT_PIN_A] == $past(boot_mode[0]) &&
                          pad_oe[ALT_PIN_B] == $past(boot_mode[3]) &&
                          pad_out[ALT_PIN_B] == $past(boot_mode[2])));

    // R3
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DATA) |=> (pad_out == $past(bus_wdata)));

    // R3
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_CFG) |=> (pad_oe == $past(bus_wdata)));

    // R4
    pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0) && ((pad_pu & ~pad_out) == '0));

    // R5
    pin_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && bus_addr == ADDR_PIN) |->
            (bus_rdata == $past(pad_in, 2)));

    // R6
    pin_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_PIN) |=>
            ($stable(pad_oe) && $stable(pad_out)));

    // R7
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped) |=> ($stable(pad_oe) && $stable(pad_out)));

    // R7
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == '0));

endmodule

bind gpio_port gpio_port_chk #(
    .PINS      (PINS),
    .ADDR_W    (ADDR_W),
    .ADDR_DATA (ADDR_DATA),
    .ADDR_CFG  (ADDR_CFG),
    .ADDR_PIN  (ADDR_PIN),
    .ALT_PIN_A (ALT_PIN_A),
    .ALT_PIN_B (ALT_PIN_B)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_mode (boot_mode),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu)
);

// File: tb/test_gpio_port.sv
// Scoreboard bench for gpio_port: driver tasks queue expected items,
// a monitor pops and compares them against the ports.
module test_gpio_port;

    localparam logic [7:0] A_DATA = 8'hB2;
    localparam logic [7:0] A_CFG  = 8'hB3;
    localparam logic [7:0] A_PIN  = 8'hB4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] boot_mode = 4'h0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;
    logic [7:0] pad_pu;
    logic [7:0] ext_drv = 8'h00;

    // Reference model of the registers
    logic [7:0] m_cfg = 8'h00;
    logic [7:0] m_data = 8'h00;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;   // 0 rdata, 1 oe, 2 out, 3 pu
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;

    always #5 clk = ~clk;

    // Pad model: driven pins show their value, pulled-up pins read 1,
    // floating pins follow the external driver
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & pad_pu) |
                    (~pad_oe & ~pad_pu & ext_drv);

    gpio_port i_gpio_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_mode (boot_mode),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_pu    (pad_pu)
    );

    // Monitor: pop every queued item and compare it with the ports
    always begin
        @(sample_ev);
        #1;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it = sb_q.pop_front();
            case (it.kind)
                0:       got = bus_rdata;
                1:       got = pad_oe;
                2:       got = pad_out;
                default: got = pad_pu;
            endcase
            total++;
            if (got !== it.exp) begin
                bad++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h",
                         it.tag, it.kind, got, it.exp);
            end
        end
    end

    task automatic push(input int kind, input logic [7:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic bus_write(input logic [7:0] addr, input logic [7:0] val);
        @(negedge clk);
        bus_addr  = addr;
        bus_wdata = val;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = 8'h00;
        if (addr == A_CFG)  m_cfg  = val;
        if (addr == A_DATA) m_data = val;
    endtask

    task automatic read_check(input logic [7:0] addr, input logic [7:0] exp,
                              input string tag);
        @(negedge clk);
        bus_addr = addr;
        push(0, exp, tag);
        -> sample_ev;
        #3;
        bus_addr = 8'h00;
    endtask

    task automatic pads_check(input string tag);
        @(negedge clk);
        push(1, m_cfg, tag);
        push(2, m_data, tag);
        push(3, m_data & ~m_cfg, tag);
        -> sample_ev;
        #3;
    endtask

    function automatic logic [7:0] pin_level();
        return (m_cfg & m_data) | (~m_cfg & m_data) | (~m_cfg & ~m_data & ext_drv);
    endfunction

    task automatic apply_reset(input logic [3:0] bm);
        @(negedge clk);
        rst_n = 1'b0;
        boot_mode = bm;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_cfg  = {2'b00, bm[3], 4'b0000, bm[1]};
        m_data = {2'b00, bm[2], 4'b0000, bm[0]};
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    // Stimulus
    initial begin
        // R2: pin 0 drives low (10), pin 5 drives high (11)
        apply_reset(4'b1110);
        read_check(A_CFG, 8'h21, "R2 boot cfg");
        read_check(A_DATA, 8'h20, "R2 boot data");
        pads_check("R2 boot pads");
        // R2: both alternate pins pulled up (01)
        apply_reset(4'b0101);
        read_check(A_CFG, 8'h00, "R2 pullup cfg");
        read_check(A_DATA, 8'h21, "R2 pullup data");
        pads_check("R2 pullup pads");
        // R1: normal reset, all floating
        apply_reset(4'b0000);
        read_check(A_CFG, 8'h00, "R1 reset cfg");
        read_check(A_DATA, 8'h00, "R1 reset data");
        pads_check("R1 reset pads");

        // R3/R4: every pin in each mode, then a mixed byte
        for (int m = 0; m < 4; m++) begin
            bus_write(A_CFG, (m >= 2) ? 8'hFF : 8'h00);
            bus_write(A_DATA, (m % 2 == 1) ? 8'hFF : 8'h00);
            read_check(A_CFG, m_cfg, "R3 cfg readback");
            read_check(A_DATA, m_data, "R3 data readback");
            pads_check("R4 uniform mode");
        end
        bus_write(A_CFG, 8'h5A);
        bus_write(A_DATA, 8'h3C);
        read_check(A_CFG, 8'h5A, "R3 mixed cfg");
        read_check(A_DATA, 8'h3C, "R3 mixed data");
        pads_check("R4 mixed modes");

        // R5: pin register follows pads in every mode
        ext_drv = 8'hA5;
        repeat (3) @(negedge clk);
        read_check(A_PIN, pin_level(), "R5 mixed pins");
        bus_write(A_CFG, 8'h00);
        bus_write(A_DATA, 8'h00);
        ext_drv = 8'h96;
        repeat (3) @(negedge clk);
        read_check(A_PIN, 8'h96, "R5 floating pins");
        bus_write(A_CFG, 8'hF0);
        bus_write(A_DATA, 8'h0F);
        ext_drv = 8'h00;
        repeat (3) @(negedge clk);
        read_check(A_PIN, pin_level(), "R5 drive low and pullup");

        // R6: pin register is read-only
        bus_write(A_PIN, 8'hFF);
        bus_write(A_PIN, 8'h00);
        read_check(A_CFG, 8'hF0, "R6 cfg after pin write");
        read_check(A_DATA, 8'h0F, "R6 data after pin write");
        pads_check("R6 pads after pin write");

        // R7: unmapped addresses
        bus_write(8'hB1, 8'hAA);
        bus_write(8'hB5, 8'h55);
        bus_write(8'h32, 8'hC3);
        bus_write(8'h33, 8'h3C);
        read_check(A_CFG, 8'hF0, "R7 cfg unchanged");
        read_check(A_DATA, 8'h0F, "R7 data unchanged");
        pads_check("R7 pads unchanged");
        read_check(8'hB1, 8'h00, "R7 read B1");
        read_check(8'hB5, 8'h00, "R7 read B5");
        read_check(8'h00, 8'h00, "R7 read 00");
        read_check(8'hFF, 8'h00, "R7 read FF");

        repeat (2) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule